// File: doc/BRIEF.md
# Home-Node Directory State Controller

This block is the home-side directory for one slice of distributed shared memory. For every memory block in its slice it stores a coherence state and a bit-vector with one bit per node. The bit-vector records which nodes hold a copy of the block. Requesting nodes send read-miss, write-miss and writeback messages. The controller answers with point-to-point messages: a data reply to the requester, invalidates addressed only to the nodes that hold copies, and fetches addressed to the current owner. It also raises a strobe whenever the memory copy of a block must be refreshed.

One request is accepted in any cycle. All resulting messages appear together one clock later, and the directory entry is updated on the same edge. A combinational lookup port exposes the stored state and sharer vector of any block. This lets the surrounding logic, or a bench, observe the directory without disturbing it. The interconnect, the node caches and the data storage are outside the block.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block reads back as Uncached with an empty sharer vector, and all message valids are low.
- R2: A read miss (`req_kind` = 0) to an Uncached or Shared block produces a data reply to the requester one cycle later. It sets the requester's sharer bit and leaves the block Shared.
- R3: A write miss (`req_kind` = 1) to an Uncached block produces a data reply and no invalidate. The block becomes Modified with only the requester's bit set.
- R4: A write miss to a Shared block sends one invalidate whose mask is the sharer vector without the requester's bit. The invalidate valid is low when that mask is empty. A reply is sent, and the block becomes Modified, owned by the requester alone.
- R5: A read miss to a Modified block from a node other than the owner sends a fetch to the owner, strobes the memory update and replies to the requester. The block becomes Shared, with the owner and the requester as sharers.
- R6: A write miss to a Modified block from a node other than the owner sends a fetch to the owner and an invalidate to the owner alone. It strobes the memory update and replies. Ownership moves to the requester, and the block stays Modified.
- R7: A writeback (`req_kind` = 2) from the owner of a Modified block strobes the memory update and sends no reply. The block returns to Uncached with an empty sharer vector.
- R8: A writeback from a non-owner, a writeback to a block that is not Modified, or a request with `req_kind` = 3 has no effect. No message valid rises and the block's state and sharers are unchanged.
- R9: A read or write miss from the node that already owns a Modified block gets a data reply and nothing else. The entry is unchanged.
- R10: The lookup port encodes Uncached as 0, Shared as 1 and Modified as 2. A Modified block always has exactly one sharer bit set, an Uncached block none, and a Shared block at least one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 writeback, 3 no operation |
| req_node | input | NODE_W | Requesting node index |
| req_block | input | BLK_W | Target block index |
| rsp_valid | output | 1 | Data reply valid |
| rsp_node | output | NODE_W | Node receiving the data reply |
| msg_block | output | BLK_W | Block that all outgoing messages of this cycle refer to |
| inv_valid | output | 1 | Invalidate valid |
| inv_mask | output | N_NODES | Nodes that receive the invalidate |
| fetch_valid | output | 1 | Fetch-from-owner valid |
| fetch_node | output | NODE_W | Owner node to fetch from |
| mem_upd_valid | output | 1 | Memory copy of msg_block must be refreshed |
| qry_block | input | BLK_W | Lookup block index |
| qry_state | output | 2 | Stored state of qry_block |
| qry_sharers | output | N_NODES | Stored sharer vector of qry_block |

## Verification
The bench builds the controller with 4 nodes and 8 blocks. At that size every sharer pattern of a 4-bit vector is reachable, and a few hundred operations visit each of the 8 entries many times. A directed sequence first drives one block through every transition, including the ignored writebacks and the owner re-miss. A deterministic pseudo-random stream then mixes all four request kinds over all nodes and blocks. After every operation the lookup port is swept over every block. Each sweep compares the stored entry with an arithmetic model and checks the one-owner and empty-Uncached invariants.

// File: rtl/dir_pkg.sv
package dir_pkg;
   typedef enum logic [1:0] {
      DS_UNC = 2'd0,
      DS_SHR = 2'd1,
      DS_MOD = 2'd2
   } dstate_t;

   typedef enum logic [1:0] {
      RQ_RD   = 2'd0,
      RQ_WR   = 2'd1,
      RQ_WB   = 2'd2,
      RQ_NONE = 2'd3
   } rkind_t;
endpackage

// File: rtl/dir_table.sv
module dir_table
   import dir_pkg::*;
#(
   parameter int N_BLOCKS = 8,
   parameter int N_NODES  = 4,
   localparam int BLK_W   = $clog2(N_BLOCKS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [BLK_W-1:0]   wr_idx,
   input  dstate_t            wr_state,
   input  logic [N_NODES-1:0] wr_sh,
   input  logic [BLK_W-1:0]   rd_idx,
   output dstate_t            rd_state,
   output logic [N_NODES-1:0] rd_sh,
   input  logic [BLK_W-1:0]   q_idx,
   output dstate_t            q_state,
   output logic [N_NODES-1:0] q_sh
);
   dstate_t            st_q [N_BLOCKS];
   logic [N_NODES-1:0] sh_q [N_BLOCKS];

   for (genvar e = 0; e < N_BLOCKS; e++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q[e] <= DS_UNC;
            sh_q[e] <= '0;
         end else if (we && (wr_idx == BLK_W'(e))) begin
            st_q[e] <= wr_state;
            sh_q[e] <= wr_sh;
         end
      end

      AST_ENTRY_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
         st_q[e] != dstate_t'(2'd3)); // R10
      AST_ENTRY_MOD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
         (st_q[e] == DS_MOD) |-> ($countones(sh_q[e]) == 1)); // R10
      AST_ENTRY_UNC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
         (st_q[e] == DS_UNC) |-> (sh_q[e] == '0)); // R10
   end

   assign rd_state = st_q[rd_idx];
   assign rd_sh    = sh_q[rd_idx];
   assign q_state  = st_q[q_idx];
   assign q_sh     = sh_q[q_idx];
endmodule

// File: rtl/dir_next.sv
module dir_next
   import dir_pkg::*;
#(
   parameter int N_NODES = 4,
   localparam int NODE_W = $clog2(N_NODES)
) (
   input  rkind_t             kind,
   input  logic [NODE_W-1:0]  node,
   input  dstate_t            cur_state,
   input  logic [N_NODES-1:0] cur_sh,
   output logic               upd,
   output dstate_t            nxt_state,
   output logic [N_NODES-1:0] nxt_sh,
   output logic               do_reply,
   output logic [N_NODES-1:0] inv_mask,
   output logic               do_fetch,
   output logic [NODE_W-1:0]  fetch_node,
   output logic               do_memwr
);
   logic [N_NODES-1:0] req_bit;
   logic [NODE_W-1:0]  owner;
   logic               req_owns;

   assign req_bit  = N_NODES'(1) << node;
   assign req_owns = (cur_sh == req_bit);

   always_comb begin
      owner = '0;
      for (int i = 0; i < N_NODES; i++)
         if (cur_sh[i]) owner = NODE_W'(i);
   end

   always_comb begin
      upd        = 1'b0;
      nxt_state  = cur_state;
      nxt_sh     = cur_sh;
      do_reply   = 1'b0;
      inv_mask   = '0;
      do_fetch   = 1'b0;
      fetch_node = owner;
      do_memwr   = 1'b0;
      unique case (kind)
         RQ_RD: begin
            do_reply = 1'b1;
            if (cur_state != DS_MOD || !req_owns) begin
               upd       = 1'b1;
               nxt_state = DS_SHR;
               nxt_sh    = cur_sh | req_bit;
               if (cur_state == DS_MOD) begin
                  do_fetch = 1'b1;
                  do_memwr = 1'b1;
               end
            end
         end
         RQ_WR: begin
            do_reply = 1'b1;
            if (cur_state != DS_MOD || !req_owns) begin
               upd       = 1'b1;
               nxt_state = DS_MOD;
               nxt_sh    = req_bit;
               inv_mask  = cur_sh & ~req_bit;
               if (cur_state == DS_MOD) begin
                  do_fetch = 1'b1;
                  do_memwr = 1'b1;
               end
            end
         end
         RQ_WB: begin
            if (cur_state == DS_MOD && req_owns) begin
               upd       = 1'b1;
               nxt_state = DS_UNC;
               nxt_sh    = '0;
               do_memwr  = 1'b1;
            end
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
   import dir_pkg::*;
#(
   parameter int N_NODES  = 4,
   parameter int N_BLOCKS = 8,
   localparam int NODE_W  = $clog2(N_NODES),
   localparam int BLK_W   = $clog2(N_BLOCKS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [1:0]         req_kind,
   input  logic [NODE_W-1:0]  req_node,
   input  logic [BLK_W-1:0]   req_block,
   output logic               rsp_valid,
   output logic [NODE_W-1:0]  rsp_node,
   output logic [BLK_W-1:0]   msg_block,
   output logic               inv_valid,
   output logic [N_NODES-1:0] inv_mask,
   output logic               fetch_valid,
   output logic [NODE_W-1:0]  fetch_node,
   output logic               mem_upd_valid,
   input  logic [BLK_W-1:0]   qry_block,
   output logic [1:0]         qry_state,
   output logic [N_NODES-1:0] qry_sharers
);
   if (N_NODES < 2 || N_NODES > 32 || (1 << NODE_W) != N_NODES) begin : g_bad_nodes
      $error("dir_home_ctrl: N_NODES must be a power of two in 2..32");
   end
   if (N_BLOCKS < 2 || N_BLOCKS > 1024 || (1 << BLK_W) != N_BLOCKS) begin : g_bad_blocks
      $error("dir_home_ctrl: N_BLOCKS must be a power of two in 2..1024");
   end

   dstate_t            cur_state, nxt_state, q_state;
   logic [N_NODES-1:0] cur_sh, nxt_sh, n_inv;
   logic               n_upd, n_reply, n_fetch, n_memwr;
   logic [NODE_W-1:0]  n_fnode;

   dir_table #(.N_BLOCKS(N_BLOCKS), .N_NODES(N_NODES)) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (req_valid && n_upd),
      .wr_idx   (req_block),
      .wr_state (nxt_state),
      .wr_sh    (nxt_sh),
      .rd_idx   (req_block),
      .rd_state (cur_state),
      .rd_sh    (cur_sh),
      .q_idx    (qry_block),
      .q_state  (q_state),
      .q_sh     (qry_sharers)
   );

   dir_next #(.N_NODES(N_NODES)) u_next (
      .kind       (rkind_t'(req_kind)),
      .node       (req_node),
      .cur_state  (cur_state),
      .cur_sh     (cur_sh),
      .upd        (n_upd),
      .nxt_state  (nxt_state),
      .nxt_sh     (nxt_sh),
      .do_reply   (n_reply),
      .inv_mask   (n_inv),
      .do_fetch   (n_fetch),
      .fetch_node (n_fnode),
      .do_memwr   (n_memwr)
   );

   assign qry_state = q_state;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_node      <= '0;
         msg_block     <= '0;
         inv_valid     <= 1'b0;
         inv_mask      <= '0;
         fetch_valid   <= 1'b0;
         fetch_node    <= '0;
         mem_upd_valid <= 1'b0;
      end else begin
         rsp_valid     <= req_valid && n_reply;
         rsp_node      <= req_node;
         msg_block     <= req_block;
         inv_valid     <= req_valid && (n_inv != '0);
         inv_mask      <= req_valid ? n_inv : '0;
         fetch_valid   <= req_valid && n_fetch;
         fetch_node    <= n_fnode;
         mem_upd_valid <= req_valid && n_memwr;
      end
   end

   AST_INV_SKIPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid |-> (rsp_valid && !inv_mask[rsp_node])); // R4
   AST_WB_NO_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 2'd2) |=> !rsp_valid); // R7
   AST_NOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 2'd3) |=> !(rsp_valid || inv_valid || fetch_valid || mem_upd_valid)); // R8
   AST_FETCH_HAS_UPD: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_valid |-> (mem_upd_valid && rsp_valid && fetch_node != rsp_node)); // R5
   AST_MOD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_state == DS_MOD) |-> ($countones(cur_sh) == 1)); // R10
endmodule

// File: tb/test_dir_home_ctrl.sv
module test_dir_home_ctrl;
   localparam int NN = 4;
   localparam int NB = 8;
   localparam int NW = 2;
   localparam int BW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_kind = '0;
   logic [NW-1:0] req_node = '0;
   logic [BW-1:0] req_block = '0;
   logic          rsp_valid, inv_valid, fetch_valid, mem_upd_valid;
   logic [NW-1:0] rsp_node, fetch_node;
   logic [BW-1:0] msg_block;
   logic [NN-1:0] inv_mask, qry_sharers;
   logic [BW-1:0] qry_block = '0;
   logic [1:0]    qry_state;

   int checks = 0;
   int errors = 0;
   int m_st [NB];
   int m_sh [NB];

   always #10 clk = ~clk;

   dir_home_ctrl #(.N_NODES(NN), .N_BLOCKS(NB)) i_dir_home_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_node(req_node), .req_block(req_block), .rsp_valid(rsp_valid),
      .rsp_node(rsp_node), .msg_block(msg_block), .inv_valid(inv_valid),
      .inv_mask(inv_mask), .fetch_valid(fetch_valid), .fetch_node(fetch_node),
      .mem_upd_valid(mem_upd_valid), .qry_block(qry_block),
      .qry_state(qry_state), .qry_sharers(qry_sharers)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic sweep_table();
      for (int b = 0; b < NB; b++) begin
         qry_block = BW'(b);
         #1;
         chk("R10", "lookup state", int'(qry_state), m_st[b]);
         chk("R10", "lookup sharers", int'(qry_sharers), m_sh[b]);
         if (qry_state == 2'd2)
            chk("R10", "modified one owner", $countones(qry_sharers), 1);
         else if (qry_state == 2'd0)
            chk("R10", "uncached empty", $countones(qry_sharers), 0);
         else
            chk("R10", "shared nonempty", int'($countones(qry_sharers) > 0), 1);
      end
   endtask

   task automatic do_req(input int k, input int nd, input int bk);
      string tg;
      int st, sh, rb, own;
      int erep, einv, efetch, emem;
      st = m_st[bk]; sh = m_sh[bk]; rb = 1 << nd;
      own = 0;
      for (int i = 0; i < NN; i++) if (sh[i]) own = i;
      erep = 0; einv = 0; efetch = 0; emem = 0; tg = "R8";
      if (k == 0) begin
         erep = 1;
         if (st != 2) begin tg = "R2"; m_st[bk] = 1; m_sh[bk] = sh | rb; end
         else if (sh == rb) tg = "R9";
         else begin tg = "R5"; efetch = 1; emem = 1; m_st[bk] = 1; m_sh[bk] = sh | rb; end
      end else if (k == 1) begin
         erep = 1;
         if (st == 0) begin tg = "R3"; m_st[bk] = 2; m_sh[bk] = rb; end
         else if (st == 1) begin tg = "R4"; einv = sh & ~rb; m_st[bk] = 2; m_sh[bk] = rb; end
         else if (sh == rb) tg = "R9";
         else begin tg = "R6"; einv = sh; efetch = 1; emem = 1; m_sh[bk] = rb; end
      end else if (k == 2) begin
         if (st == 2 && sh == rb) begin tg = "R7"; emem = 1; m_st[bk] = 0; m_sh[bk] = 0; end
      end
      req_kind = 2'(k); req_node = NW'(nd); req_block = BW'(bk); req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(tg, "rsp_valid", int'(rsp_valid), erep);
      if (erep != 0) chk(tg, "rsp_node", int'(rsp_node), nd);
      if ((erep | emem) != 0) chk(tg, "msg_block", int'(msg_block), bk);
      chk(tg, "inv_valid", int'(inv_valid), int'(einv != 0));
      chk(tg, "inv_mask", int'(inv_mask), einv);
      chk(tg, "fetch_valid", int'(fetch_valid), efetch);
      if (efetch != 0) chk(tg, "fetch_node", int'(fetch_node), own);
      chk(tg, "mem_upd_valid", int'(mem_upd_valid), emem);
      sweep_table();
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL R1 watchdog expired: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int seed;
      for (int b = 0; b < NB; b++) begin m_st[b] = 0; m_sh[b] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset contents and idle outputs
      chk("R1", "rsp_valid", int'(rsp_valid), 0);
      chk("R1", "inv_valid", int'(inv_valid), 0);
      chk("R1", "fetch_valid", int'(fetch_valid), 0);
      chk("R1", "mem_upd_valid", int'(mem_upd_valid), 0);
      sweep_table();
      // directed walk over block 5
      do_req(0, 0, 5); // R2 uncached
      do_req(0, 1, 5); // R2 shared
      do_req(1, 2, 5); // R4 invalidate nodes 0 and 1
      do_req(0, 3, 5); // R5 fetch from 2
      do_req(1, 1, 5); // R4 mask nodes 2 and 3
      do_req(2, 0, 5); // R8 non-owner writeback
      do_req(2, 1, 5); // R7 owner writeback
      do_req(2, 1, 5); // R8 writeback to uncached
      do_req(1, 0, 5); // R3
      do_req(1, 0, 5); // R9 owner write again
      do_req(0, 0, 5); // R9 owner read
      do_req(1, 3, 5); // R6 ownership move
      do_req(3, 3, 5); // R8 no-op kind
      do_req(0, 3, 5); // R9
      do_req(1, 3, 2); // R3 other block
      do_req(1, 3, 2); // R9
      // pseudo-random sweep over all kinds, nodes, blocks
      seed = 12345;
      for (int n = 0; n < 900; n++) begin
         seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
         do_req((seed >> 8) % 4, (seed >> 12) % NN, (seed >> 16) % NB);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule